// File: doc/BRIEF.md
# I2C Controller Register Front End

This block is the software-visible register layer of an I2C controller. It connects a simple single-cycle bus (byte address, write enable, write data, combinational read data) to a separate bit-level protocol engine. It holds the control byte, a status byte, the data byte, the own-address byte and the two SCL half-period counts. It also raises an interrupt towards the processor.

Software never writes the control byte directly. One address ORs the written mask into it, and another address clears the masked bits. The engine reports progress through a one-cycle event strobe with a 5-bit state code. That strobe sets the serial-interrupt flag (control bit 3) and latches the code into the top five bits of the status byte. The three low status bits are zero, so the status value can index a table of handlers at an 8-byte stride. While the flag is pending the status byte is frozen, and software reads a stable code until it clears the flag. Received bytes from the engine land in the data register.

Top module: `i2c_regfile`

## Requirements
- R1: A write to byte offset 0x00 ORs the written byte into the control register, and written 0 bits leave their control bits unchanged.
- R2: A write to byte offset 0x18 clears every control bit whose written bit is 1 and leaves the others unchanged.
- R3: Reading offset 0x00 returns the control register, and reading the write-only offset 0x18 returns 0x00.
- R4: The status byte at offset 0x04 is read-only: bus writes to it are ignored and its bits 2:0 always read 0.
- R5: An engine event strobe while the serial-interrupt flag (control bit 3) is clear sets the flag and loads the presented 5-bit code into status bits 7:3 at the same clock edge.
- R6: While the serial-interrupt flag is set, further engine events leave the status byte unchanged.
- R7: When a clear write to offset 0x18 and an engine event fall in the same cycle, the serial-interrupt flag ends up set.
- R8: The `irq` output is 1 exactly when control bit 3 (serial interrupt) and control bit 6 (interface enable) are both 1.
- R9: After reset, control, data and own address read 0x00, status reads 0xF8, and both SCL counts read 0x04.
- R10: The data register at offset 0x08 takes bus writes. An engine receive strobe loads the received byte instead, even when a bus write to it happens in the same cycle.
- R11: The own-address byte at offset 0x0C is read and written by the bus, and its bits 7:1 drive `slave_addr` and its bit 0 drives `gc_en`.
- R12: The SCL high count (offset 0x10) and low count (offset 0x14) are read/write bytes driven on `scl_high` and `scl_low`.
- R13: Reads of offset 0x1C or of any address that is not a multiple of four return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for the current address |
| eng_evt | input | 1 | Engine event strobe that sets the serial-interrupt flag |
| eng_code | input | CODE_W | State code presented with the event strobe |
| eng_rx_vld | input | 1 | Engine receive strobe |
| eng_rx_byte | input | REG_W | Received byte |
| ctrl_out | output | REG_W | Control register contents to the engine |
| tx_byte | output | REG_W | Data register contents to the engine |
| slave_addr | output | REG_W-1 | Own 7-bit slave address |
| gc_en | output | 1 | General-call response enable |
| scl_high | output | REG_W | SCL high-phase count |
| scl_low | output | REG_W | SCL low-phase count |
| irq | output | 1 | Interrupt request |

## Verification
The register map is exercised with writes of sparse, dense, all-ones and all-zeros masks to the set and clear offsets. This separates a true OR/AND-NOT update from a plain overwrite, and it shows that zero bits change nothing. Event sequences with the flag clear, with it pending, and with it colliding with a clear write tell the load, the freeze and the priority cases apart. The interrupt is observed with the enable bit on and off. A bus write to the data register that collides with a receive strobe shows which source wins.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  // Word slots in the map; the index is byte address divided by four.
  typedef enum logic [2:0] {
    SLOT_SETC = 3'd0,
    SLOT_STAT = 3'd1,
    SLOT_DATA = 3'd2,
    SLOT_OWN  = 3'd3,
    SLOT_SCLH = 3'd4,
    SLOT_SCLL = 3'd5,
    SLOT_CLRC = 3'd6,
    SLOT_NONE = 3'd7
  } slot_e;

  localparam int SLOT_BITS = 3;
  localparam int BYTE_LSB  = 2;

endpackage

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg #(
  parameter int W      = 8,
  parameter int SI_BIT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] mask,
  input  logic         evt,
  output logic [W-1:0] ctrl_q
);

  logic [W-1:0] ctrl_nxt;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (set_we) ctrl_nxt = ctrl_nxt | mask;
    if (clr_we) ctrl_nxt = ctrl_nxt & ~mask;
    if (evt)    ctrl_nxt[SI_BIT] = 1'b1;   // engine set wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nxt;
  end

endmodule

// File: rtl/i2c_stat_cap.sv
module i2c_stat_cap #(
  parameter int              W        = 8,
  parameter int              CODE_W   = 5,
  parameter logic [CODE_W-1:0] RST_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic              si_pending,
  input  logic [CODE_W-1:0] code,
  output logic [W-1:0]      stat_q
);

  localparam int PAD_W = W - CODE_W;

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)                    code_q <= RST_CODE;
    else if (evt && !si_pending) code_q <= code;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign stat_q = {code_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign stat_q = code_q;
    end
  endgenerate

endmodule

// File: rtl/i2c_plain_reg.sv
module i2c_plain_reg #(
  parameter int         W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_we,
  input  logic [W-1:0] bus_d,
  input  logic         ld,
  input  logic [W-1:0] ld_d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)         q <= RST;
    else if (ld)     q <= ld_d;     // engine load has priority
    else if (bus_we) q <= bus_d;
  end

endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 8,
  parameter int CODE_W = 5,
  parameter int SI_BIT = 3,
  parameter int EN_BIT = 6,
  parameter logic [REG_W-1:0] SCL_RST = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              eng_evt,
  input  logic [CODE_W-1:0] eng_code,
  input  logic              eng_rx_vld,
  input  logic [REG_W-1:0]  eng_rx_byte,
  output logic [REG_W-1:0]  ctrl_out,
  output logic [REG_W-1:0]  tx_byte,
  output logic [REG_W-2:0]  slave_addr,
  output logic              gc_en,
  output logic [REG_W-1:0]  scl_high,
  output logic [REG_W-1:0]  scl_low,
  output logic              irq
);

  localparam int HI_LSB = BYTE_LSB + SLOT_BITS;

  slot_e      slot;
  logic       aligned;
  logic [REG_W-1:0] ctrl_q, stat_q, data_q, own_q, sclh_q, scll_q;

  assign slot    = slot_e'(bus_addr[HI_LSB-1:BYTE_LSB]);
  assign aligned = (bus_addr[BYTE_LSB-1:0] == '0) && ((bus_addr >> HI_LSB) == '0);

  logic wr_set, wr_clr, wr_data, wr_own, wr_sclh, wr_scll;
  assign wr_set  = bus_we && aligned && (slot == SLOT_SETC);
  assign wr_clr  = bus_we && aligned && (slot == SLOT_CLRC);
  assign wr_data = bus_we && aligned && (slot == SLOT_DATA);
  assign wr_own  = bus_we && aligned && (slot == SLOT_OWN);
  assign wr_sclh = bus_we && aligned && (slot == SLOT_SCLH);
  assign wr_scll = bus_we && aligned && (slot == SLOT_SCLL);

  i2c_ctrl_reg #(.W(REG_W), .SI_BIT(SI_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .set_we(wr_set), .clr_we(wr_clr),
    .mask(bus_wdata), .evt(eng_evt), .ctrl_q(ctrl_q)
  );

  i2c_stat_cap #(.W(REG_W), .CODE_W(CODE_W), .RST_CODE('1)) u_stat (
    .clk(clk), .rst(rst), .evt(eng_evt), .si_pending(ctrl_q[SI_BIT]),
    .code(eng_code), .stat_q(stat_q)
  );

  i2c_plain_reg #(.W(REG_W), .RST('0)) u_data (
    .clk(clk), .rst(rst), .bus_we(wr_data), .bus_d(bus_wdata),
    .ld(eng_rx_vld), .ld_d(eng_rx_byte), .q(data_q)
  );

  i2c_plain_reg #(.W(REG_W), .RST('0)) u_own (
    .clk(clk), .rst(rst), .bus_we(wr_own), .bus_d(bus_wdata),
    .ld(1'b0), .ld_d('0), .q(own_q)
  );

  i2c_plain_reg #(.W(REG_W), .RST(SCL_RST)) u_sclh (
    .clk(clk), .rst(rst), .bus_we(wr_sclh), .bus_d(bus_wdata),
    .ld(1'b0), .ld_d('0), .q(sclh_q)
  );

  i2c_plain_reg #(.W(REG_W), .RST(SCL_RST)) u_scll (
    .clk(clk), .rst(rst), .bus_we(wr_scll), .bus_d(bus_wdata),
    .ld(1'b0), .ld_d('0), .q(scll_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (slot)
        SLOT_SETC: bus_rdata = ctrl_q;
        SLOT_STAT: bus_rdata = stat_q;
        SLOT_DATA: bus_rdata = data_q;
        SLOT_OWN:  bus_rdata = own_q;
        SLOT_SCLH: bus_rdata = sclh_q;
        SLOT_SCLL: bus_rdata = scll_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign ctrl_out   = ctrl_q;
  assign tx_byte    = data_q;
  assign slave_addr = own_q[REG_W-1:1];
  assign gc_en      = own_q[0];
  assign scl_high   = sclh_q;
  assign scl_low    = scll_q;
  assign irq        = ctrl_q[SI_BIT] & ctrl_q[EN_BIT];

endmodule

// File: rtl/i2c_regfile_chk.sv
module i2c_regfile_chk #(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 8,
  parameter int CODE_W = 5,
  parameter int SI_BIT = 3,
  parameter int EN_BIT = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              eng_evt,
  input logic [CODE_W-1:0] eng_code,
  input logic              eng_rx_vld,
  input logic [REG_W-1:0]  eng_rx_byte,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  stat_q,
  input logic [REG_W-1:0]  data_q,
  input logic              irq
);

  localparam int PAD_W = REG_W - CODE_W;

  logic hit_set, hit_clr, hit_stat;
  assign hit_set  = (bus_addr == ADDR_W'(0));
  assign hit_clr  = (bus_addr == ADDR_W'(24));
  assign hit_stat = (bus_addr == ADDR_W'(4));

  a_r1_set_or: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_set) |=> ((ctrl_q & $past(bus_wdata)) == $past(bus_wdata)));

  a_r2_clr_mask: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_clr && !eng_evt) |=> ((ctrl_q & $past(bus_wdata)) == '0));

  a_r4_stat_low_zero: assert property (@(posedge clk) disable iff (rst)
    hit_stat |-> (bus_rdata[PAD_W-1:0] == '0));

  a_r5_stat_load: assert property (@(posedge clk) disable iff (rst)
    (eng_evt && !ctrl_q[SI_BIT]) |=> (stat_q[REG_W-1:PAD_W] == $past(eng_code)));

  a_r6_stat_frozen: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[SI_BIT] |=> $stable(stat_q));

  a_r7_evt_wins: assert property (@(posedge clk) disable iff (rst)
    eng_evt |=> ctrl_q[SI_BIT]);

  a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ctrl_q[EN_BIT] && ctrl_q[SI_BIT]));

  a_r10_rx_priority: assert property (@(posedge clk) disable iff (rst)
    eng_rx_vld |=> (data_q == $past(eng_rx_byte)));

endmodule

bind i2c_regfile i2c_regfile_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .CODE_W(CODE_W),
  .SI_BIT(SI_BIT), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_evt(eng_evt),
  .eng_code(eng_code), .eng_rx_vld(eng_rx_vld), .eng_rx_byte(eng_rx_byte),
  .ctrl_q(ctrl_q), .stat_q(stat_q), .data_q(data_q), .irq(irq)
);

// File: tb/i2c_regfile_bench.sv
module i2c_regfile_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       eng_evt = 1'b0;
  logic [4:0] eng_code = '0;
  logic       eng_rx_vld = 1'b0;
  logic [7:0] eng_rx_byte = '0;
  logic [7:0] ctrl_out, tx_byte, scl_high, scl_low;
  logic [6:0] slave_addr;
  logic       gc_en, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  i2c_regfile u_i2c_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_evt(eng_evt),
    .eng_code(eng_code), .eng_rx_vld(eng_rx_vld), .eng_rx_byte(eng_rx_byte),
    .ctrl_out(ctrl_out), .tx_byte(tx_byte), .slave_addr(slave_addr),
    .gc_en(gc_en), .scl_high(scl_high), .scl_low(scl_low), .irq(irq)
  );

  // {req[3:0], we, waddr[4:0], wdata[7:0], raddr[4:0], expected[7:0]}
  localparam int NV = 13;
  localparam logic [30:0] VEC [NV] = '{
    {4'd1,  1'b1, 5'h00, 8'h44, 5'h00, 8'h44},  // R1 sparse set
    {4'd1,  1'b1, 5'h00, 8'h20, 5'h00, 8'h64},  // R1 OR keeps old bits
    {4'd2,  1'b1, 5'h18, 8'h24, 5'h00, 8'h40},  // R2 masked clear
    {4'd2,  1'b1, 5'h18, 8'h00, 5'h00, 8'h40},  // R2 zero mask no effect
    {4'd3,  1'b0, 5'h00, 8'h00, 5'h18, 8'h00},  // R3 clear offset reads zero
    {4'd4,  1'b1, 5'h04, 8'h55, 5'h04, 8'hF8},  // R4 status write ignored
    {4'd10, 1'b1, 5'h08, 8'hA5, 5'h08, 8'hA5},  // R10 bus data write
    {4'd11, 1'b1, 5'h0C, 8'h3B, 5'h0C, 8'h3B},  // R11 own address
    {4'd12, 1'b1, 5'h10, 8'h7E, 5'h10, 8'h7E},  // R12 high count
    {4'd12, 1'b1, 5'h14, 8'h19, 5'h14, 8'h19},  // R12 low count
    {4'd13, 1'b0, 5'h00, 8'h00, 5'h1C, 8'h00},  // R13 unmapped slot
    {4'd1,  1'b1, 5'h00, 8'hFF, 5'h00, 8'hFF},  // R1 all-ones set
    {4'd2,  1'b1, 5'h18, 8'hFF, 5'h00, 8'h00}   // R2 all-ones clear
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic evt(input logic [4:0] c);
    @(negedge clk);
    eng_evt = 1'b1; eng_code = c;
    @(negedge clk);
    eng_evt = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset values
    rd(5'h00, r); check("R9", r, 8'h00);
    rd(5'h04, r); check("R9", r, 8'hF8);
    rd(5'h08, r); check("R9", r, 8'h00);
    rd(5'h0C, r); check("R9", r, 8'h00);
    rd(5'h10, r); check("R9", r, 8'h04);
    rd(5'h14, r); check("R9", r, 8'h04);
    check("R9", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      if (v[26]) wr(v[25:21], v[20:13]);
      rd(v[12:8], r);
      check($sformatf("R%0d", v[30:27]), r, v[7:0]);
    end

    // R5 R8: event with flag clear and enable on
    wr(5'h00, 8'h40);
    evt(5'h08);
    rd(5'h04, r); check("R5", r, 8'h40);
    rd(5'h00, r); check("R5", r, 8'h48);
    check("R8", {7'd0, irq}, 8'h01);

    // R6: second event while pending leaves status alone
    evt(5'h0A);
    rd(5'h04, r); check("R6", r, 8'h40);

    // R2 R8: clearing the flag drops irq
    wr(5'h18, 8'h08);
    rd(5'h00, r); check("R2", r, 8'h40);
    check("R8", {7'd0, irq}, 8'h00);

    // R7: clear and event in the same cycle
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h18; bus_wdata = 8'h08;
    eng_evt = 1'b1; eng_code = 5'h03;
    @(negedge clk);
    bus_we = 1'b0; eng_evt = 1'b0;
    rd(5'h00, r); check("R7", r, 8'h48);
    rd(5'h04, r); check("R5", r, 8'h18);

    // R8: enable off masks irq with flag still set
    wr(5'h18, 8'h40);
    rd(5'h00, r); check("R8", r, 8'h08);
    check("R8", {7'd0, irq}, 8'h00);

    // R11 R12 engine-facing outputs
    check("R11", {1'b0, slave_addr}, 8'h1D);
    check("R11", {7'd0, gc_en}, 8'h01);
    check("R12", scl_high, 8'h7E);
    check("R12", scl_low, 8'h19);

    // R10: receive strobe beats a colliding bus write
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = 8'h11;
    eng_rx_vld = 1'b1; eng_rx_byte = 8'hC3;
    @(negedge clk);
    bus_we = 1'b0; eng_rx_vld = 1'b0;
    rd(5'h08, r); check("R10", r, 8'hC3);
    check("R10", tx_byte, 8'hC3);

    // R13: misaligned addresses read zero
    rd(5'h09, r); check("R13", r, 8'h00);
    rd(5'h01, r); check("R13", r, 8'h00);

    // R3: set offset mirrors control byte
    check("R3", ctrl_out, 8'h08);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule